// File: doc/BRIEF.md
# Memory-to-Memory Three-Address Arithmetic Core

This block is a small multi-cycle processor that keeps no working registers for data. Every operand and every result sits in an external word-addressed memory of 2^12 sixteen-bit words. The core reaches that memory through one port, and each access moves one whole word in one clock cycle. Each instruction occupies three consecutive words. The core fetches them one after another, reads the two source words, applies addition, subtraction or multiplication, and writes the result back to a destination word. One instruction therefore costs exactly six memory accesses.

A 32-bit running total of memory word accesses is exposed so that the memory traffic of a program can be measured directly. A first word carrying any opcode the core does not implement stops the processor for good. The word value zero is such an opcode. After a stop only a reset restarts the core.

Top module: `mm3_core`

## Requirements
- R1: After reset the access total is 0, `halted` is low, and the first access is a read of address 0.
- R2: Word 1 of an instruction carries the opcode in bits [15:12] and the destination address in bits [11:0]. Words 2 and 3 carry the first and second source addresses in bits [11:0]. Bits [15:12] of words 2 and 3 are ignored.
- R3: Each instruction makes exactly six accesses, one per cycle, in this order: reads of pc, pc+1 and pc+2, a read of source 1, a read of source 2, then one write to the destination. `mem_re` and `mem_we` are never high together.
- R4: Opcode 4'b0001 writes source1 + source2, modulo 2^16.
- R5: Opcode 4'b0010 writes source1 − source2 (first minus second), modulo 2^16.
- R6: Opcode 4'b0011 writes the low 16 bits of source1 × source2.
- R7: The program counter advances by 3 after each instruction. The fetch that follows a write returns the value just written, even when that write changed an instruction word.
- R8: `acc_count` rises by exactly one in every cycle that has a read or a write, and holds otherwise.
- R9: A first word whose opcode is none of 0001, 0010 or 0011 (0000 included) costs that single fetch. The core then raises `halted`, makes no further accesses, and freezes `acc_count` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address of the current access |
| mem_re | output | 1 | Read this cycle; data is taken from `mem_rdata` at the clock edge |
| mem_we | output | 1 | Write `mem_wdata` to `mem_addr` at the clock edge |
| mem_wdata | output | 16 | Result word being written |
| mem_rdata | input | 16 | Word read from `mem_addr`, valid in the same cycle |
| halted | output | 1 | Core has stopped on an unimplemented opcode |
| acc_count | output | 32 | Running total of memory word accesses |

## Verification
Two things can meet at one address in consecutive cycles: the result write that ends one instruction, and the fetch of the next instruction's first word. The bench provokes this with a program whose first instruction writes its sum into the opcode word of the second instruction. That word starts as zero, so the core stops there unless it sees the new value. The scoreboard predicts every access in order. It expects the rewritten word to execute as an addition to a new destination. Any halt at that address, or any access that departs from the predicted stream, is reported.

// File: rtl/mm3_core.sv
module mm3_core #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int CW  = 32,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [CW-1:0] acc_count
);

  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB = OPW'(2);
  localparam logic [OPW-1:0] OP_MUL = OPW'(3);
  localparam logic [AW-1:0]  STEP   = AW'(3);

  typedef enum logic [2:0] {S_F0, S_F1, S_F2, S_R1, S_R2, S_WR, S_HLT} state_t;

  state_t          state;
  logic [AW-1:0]   pc, dst, s1, s2;
  logic [OPW-1:0]  op;
  logic [DW-1:0]   a, b;
  logic [OPW-1:0]  fetched_op;
  logic            op_ok;

  assign fetched_op = mem_rdata[DW-1 -: OPW];
  assign op_ok      = (fetched_op == OP_ADD) || (fetched_op == OP_SUB) || (fetched_op == OP_MUL);

  always_comb begin
    case (state)
      S_F0:    mem_addr = pc;
      S_F1:    mem_addr = pc + AW'(1);
      S_F2:    mem_addr = pc + AW'(2);
      S_R1:    mem_addr = s1;
      S_R2:    mem_addr = s2;
      S_WR:    mem_addr = dst;
      default: mem_addr = pc;
    endcase
  end

  assign mem_re = (state == S_F0) || (state == S_F1) || (state == S_F2) ||
                  (state == S_R1) || (state == S_R2);
  assign mem_we = (state == S_WR);
  assign halted = (state == S_HLT);

  always_comb begin
    case (op)
      OP_ADD:  mem_wdata = a + b;
      OP_SUB:  mem_wdata = a - b;
      default: mem_wdata = a * b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F0;
      pc    <= '0;
      dst   <= '0;
      s1    <= '0;
      s2    <= '0;
      op    <= '0;
      a     <= '0;
      b     <= '0;
    end else begin
      case (state)
        S_F0: begin
          op    <= fetched_op;
          dst   <= mem_rdata[AW-1:0];
          state <= op_ok ? S_F1 : S_HLT;
        end
        S_F1: begin
          s1    <= mem_rdata[AW-1:0];
          state <= S_F2;
        end
        S_F2: begin
          s2    <= mem_rdata[AW-1:0];
          state <= S_R1;
        end
        S_R1: begin
          a     <= mem_rdata;
          state <= S_R2;
        end
        S_R2: begin
          b     <= mem_rdata;
          state <= S_WR;
        end
        S_WR: begin
          pc    <= pc + STEP;
          state <= S_F0;
        end
        default: state <= S_HLT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_count <= '0;
    else if (mem_re || mem_we)
      acc_count <= acc_count + CW'(1);
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mem_re || mem_we) |=> acc_count == $past(acc_count) + CW'(1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re || mem_we) |=> $stable(acc_count)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_re && !mem_we); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted && $stable(acc_count)); // R9
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> mem_re && mem_addr == $past(pc) + STEP); // R7

endmodule

// File: tb/mm3_core_tb.sv
`timescale 1ns/1ps
module mm3_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_re, mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic        halted;
  logic [31:0] acc_count;

  logic [15:0] mem    [0:4095];
  logic [15:0] golden [0:4095];
  logic [30:0] expq [$];
  int checks = 0;
  int fails = 0;
  int exp_total = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mm3_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .acc_count(acc_count)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input logic [1:0] k);
    case (k)
      2'd0: return "R3 fetch";
      2'd1: return "R2 operand read";
      2'd2: return "R4 R5 R6 result write";
      default: return "R9 stopping fetch";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we)) begin
      if (expq.size() == 0) begin
        check(0, "R3", "unexpected access at", mem_addr, 0);
      end else begin
        logic [30:0] it;
        it = expq.pop_front();
        check(mem_we == it[28] && mem_re == !it[28], kind_req(it[30:29]), "access direction", mem_we, it[28]);
        check(mem_addr == it[27:16], kind_req(it[30:29]), "address", mem_addr, it[27:16]);
        if (it[28])
          check(mem_wdata == it[15:0], kind_req(it[30:29]), "written data", mem_wdata, it[15:0]);
      end
    end
  end

  task automatic put(input int addr, input logic [15:0] v);
    mem[addr] = v;
    golden[addr] = v;
  endtask

  task automatic push(input logic [1:0] k, input bit we, input int addr, input logic [15:0] d);
    expq.push_back({k, we, 12'(addr), d});
    exp_total++;
  endtask

  task automatic expect_instr(input int pc, input logic [3:0] op, input int d, input int s1, input int s2);
    logic [15:0] r;
    case (op)
      4'd1: r = golden[s1] + golden[s2];
      4'd2: r = golden[s1] - golden[s2];
      default: r = golden[s1] * golden[s2];
    endcase
    push(2'd0, 0, pc, 0);
    push(2'd0, 0, pc + 1, 0);
    push(2'd0, 0, pc + 2, 0);
    push(2'd1, 0, s1, 0);
    push(2'd1, 0, s2, 0);
    push(2'd2, 1, d, r);
    golden[d] = r;
  endtask

  task automatic word3(input int pc, input logic [3:0] op, input int d, input logic [3:0] pad, input int s1, input int s2);
    put(pc, {op, 12'(d)});
    put(pc + 1, {pad, 12'(s1)});
    put(pc + 2, {pad, 12'(s2)});
  endtask

  task automatic clear;
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      golden[i] = '0;
    end
    expq.delete();
    exp_total = 0;
  endtask

  task automatic start_and_finish(input string name);
    int n;
    logic [31:0] frozen;
    @(posedge clk);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(acc_count == 0, "R1", {name, " count after reset"}, acc_count, 0);
    check(!halted, "R1", {name, " halted after reset"}, halted, 0);
    check(mem_re && mem_addr == 0, "R1", {name, " first access address"}, mem_addr, 0);
    n = 0;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(halted, "R9", {name, " halted reached"}, halted, 1);
    check(expq.size() == 0, "R3", {name, " accesses left unseen"}, expq.size(), 0);
    check(acc_count == 32'(exp_total), "R8", {name, " access total"}, acc_count, exp_total);
    frozen = acc_count;
    repeat (8) @(negedge clk);
    check(acc_count == frozen && !mem_re && !mem_we, "R9", {name, " frozen after stop"}, acc_count, frozen);
  endtask

  initial begin
    // R4 R5 R6 R7: three-instruction program, x=3, y=2, stop on 0000
    clear();
    put(200, 16'd3);
    put(201, 16'd2);
    word3(0, 4'd1, 100, 4'd0, 200, 201);
    word3(3, 4'd2, 101, 4'd0, 200, 201);
    word3(6, 4'd3, 102, 4'd0, 100, 101);
    expect_instr(0, 4'd1, 100, 200, 201);
    expect_instr(3, 4'd2, 101, 200, 201);
    expect_instr(6, 4'd3, 102, 100, 101);
    push(2'd3, 0, 9, 0);
    start_and_finish("basic");
    check(mem[102] == 16'd5, "R6", "product of sum and difference", mem[102], 5);

    // R2 R4 R5 R6: wrap, borrow, truncation, nonzero padding, stop on 0111
    clear();
    put(310, 16'hFFFF);
    put(311, 16'h0002);
    put(312, 16'h0002);
    put(313, 16'h0003);
    put(314, 16'h1234);
    put(315, 16'h0100);
    word3(0, 4'd1, 300, 4'hA, 310, 311);
    word3(3, 4'd2, 301, 4'hF, 312, 313);
    word3(6, 4'd3, 302, 4'h5, 314, 315);
    put(9, 16'h7ABC);
    expect_instr(0, 4'd1, 300, 310, 311);
    expect_instr(3, 4'd2, 301, 312, 313);
    expect_instr(6, 4'd3, 302, 314, 315);
    push(2'd3, 0, 9, 0);
    start_and_finish("wrap");
    check(mem[300] == 16'h0001, "R4", "sum wraps", mem[300], 1);
    check(mem[301] == 16'hFFFF, "R5", "difference borrows", mem[301], 16'hFFFF);
    check(mem[302] == 16'h3400, "R6", "product truncated", mem[302], 16'h3400);

    // R7: first instruction rewrites the opcode word of the second
    clear();
    put(50, 16'h1000);
    put(51, 16'h003C);
    put(52, 16'd7);
    put(53, 16'd8);
    word3(0, 4'd1, 3, 4'd0, 50, 51);
    put(3, 16'h0000);
    put(4, {4'd0, 12'd52});
    put(5, {4'd0, 12'd53});
    expect_instr(0, 4'd1, 3, 50, 51);
    expect_instr(3, 4'd1, 60, 52, 53);
    push(2'd3, 0, 6, 0);
    start_and_finish("selfmod");
    check(mem[60] == 16'd15, "R7", "rewritten instruction executed", mem[60], 15);

    // R9: program that begins with an undefined opcode
    clear();
    put(0, 16'hF123);
    push(2'd3, 0, 0, 0);
    start_and_finish("immediate stop");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule